// File: doc/BRIEF.md
# PWM Minimum Low-Time Enforcer

This block sits in the PWM path ahead of a half-bridge power stage. The stage needs some low time in every PWM frame to recharge its high-side bootstrap capacitors. The input frame rate is fixed at 384 kHz, so one frame is about 2604 ns long. Every frame must contain a continuous low interval of at least 50 ns. A near-full modulation index can leave low pulses of only about 20 ns. Such a frame would starve the bootstrap supply and could trip an undervoltage shutdown.

The block samples the incoming PWM bit and a frame-start strobe on a 200 MHz system clock. It tracks the position inside the current frame and the longest low run seen so far. If no run of `MIN_LOW` cycles has completed by the time only `MIN_LOW` cycles remain in the frame, the block forces the output low for the rest of the frame. This cuts short the end of the high time.

The default `MIN_LOW` is 10 cycles (50 ns). At the safe modulation limit of about 96.1%, a frame has roughly 101 ns (about 20 cycles) of low time, so legal frames are never touched. Any frame in which a high bit had to be suppressed sets a sticky violation flag. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `pwm_low_guard`

## Requirements
- R1: While `rst_n` is low, `pwm_out` and `viol_flag` are 0, whatever the other inputs do.
- R2: The cycle in which `frame_start` is 1 is frame position 0, and each later cycle adds one to the position. A frame that completes a continuous run of `MIN_LOW` low input cycles at a position below `FRAME_LEN-MIN_LOW` passes through unchanged, so `pwm_out` equals `pwm_in` from one cycle earlier.
- R3: In a frame that has no such run, every bit at position `FRAME_LEN-MIN_LOW` or later is output as 0. Bits at earlier positions pass through unchanged with one cycle of latency.
- R4: A frame whose input is already low over its final `MIN_LOW` positions leaves the block unchanged and does not set `viol_flag`, even if no earlier run qualified.
- R5: `viol_flag` becomes 1 in the cycle after any input bit of 1 is output as 0.
- R6: Once set, `viol_flag` stays 1 until `viol_clr` is 1 in some cycle. It reads 0 in the following cycle if no new suppression happens in the same cycle as the clear.
- R7: If a suppression and `viol_clr` fall in the same cycle, the suppression wins and `viol_flag` stays 1.
- R8: A frame shorter than `FRAME_LEN` is judged by the same position rule: only its positions at or beyond `FRAME_LEN-MIN_LOW` can be forced low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 200 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe marking position 0 of a frame |
| pwm_in | input | 1 | Incoming PWM bit |
| viol_clr | input | 1 | Write-one-to-clear for the violation flag |
| pwm_out | output | 1 | Corrected PWM bit, one cycle behind the input |
| viol_flag | output | 1 | Sticky flag: a frame needed correction |

## Verification
Two events can land in the same cycle: a high input bit suppressed in the low-time window, and a clear of the violation flag. The bench provokes this collision directly. It runs an all-high frame and pulses `viol_clr` exactly at position `FRAME_LEN-MIN_LOW`, the first forced cycle, and then expects the flag to read 1 on the next cycle. Random frames also drop clears at random positions. A reference model that works frame by frame judges each cycle's output and flag against the set-over-clear rule.

// File: rtl/pwm_low_guard.sv
module pwm_low_guard #(
  parameter int FRAME_LEN = 521,
  parameter int MIN_LOW   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic pwm_in,
  input  logic viol_clr,
  output logic pwm_out,
  output logic viol_flag
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam int RW = $clog2(MIN_LOW + 1);
  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);
  localparam logic [PW-1:0] WIN  = PW'(FRAME_LEN - MIN_LOW);
  localparam logic [RW-1:0] FULL = RW'(MIN_LOW);

  logic [PW-1:0] pos_q, pos;
  logic [RW-1:0] run_q, run_base, run_n;
  logic ok_q, ok_base, ok_n;
  logic hold_q, hold_base;
  logic force_now, out_bit, hit;

  assign pos       = frame_start ? '0 : ((pos_q == LAST) ? LAST : pos_q + 1'b1);
  assign run_base  = frame_start ? '0 : run_q;
  assign ok_base   = frame_start ? 1'b0 : ok_q;
  assign hold_base = frame_start ? 1'b0 : hold_q;

  assign force_now = (pos >= WIN) && (hold_base || ((pos == WIN) && !ok_base));
  assign out_bit   = pwm_in & ~force_now;
  assign hit       = force_now & pwm_in;

  assign run_n = out_bit ? '0 : ((run_base == FULL) ? run_base : run_base + 1'b1);
  assign ok_n  = ok_base | (run_n == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= LAST;
      run_q     <= '0;
      ok_q      <= 1'b0;
      hold_q    <= 1'b0;
      pwm_out   <= 1'b0;
      viol_flag <= 1'b0;
    end else begin
      pos_q     <= pos;
      run_q     <= run_n;
      ok_q      <= ok_n;
      hold_q    <= force_now;
      pwm_out   <= out_bit;
      viol_flag <= hit | (viol_flag & ~viol_clr);
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !force_now |=> (pwm_out == $past(pwm_in)));

  p_tail_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_now |=> !pwm_out);

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> viol_flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !hit) |=> !viol_flag);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && hit) |=> viol_flag);

  p_no_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(pwm_in));
endmodule

// File: tb/pwm_low_guard_test.sv
`timescale 1ns/1ps
module pwm_low_guard_test;
  localparam int FL = 521;
  localparam int ML = 10;
  localparam int W  = FL - ML;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic pwm_in = 1'b0;
  logic viol_clr = 1'b0;
  logic pwm_out, viol_flag;

  int tests = 0;
  int fails = 0;
  logic exp_out = 1'b0;
  logic exp_flag = 1'b0;
  logic have_prev = 1'b0;
  string prev_tag = "R2";
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_low_guard #(.FRAME_LEN(FL), .MIN_LOW(ML)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwm_in(pwm_in),
    .viol_clr(viol_clr), .pwm_out(pwm_out), .viol_flag(viol_flag));

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic qualifies(input logic [FL-1:0] b, input int len);
    int run = 0;
    for (int p = 0; p < len && p < W; p++) begin
      run = b[p] ? 0 : run + 1;
      if (run >= ML) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_frame(input logic [FL-1:0] b, input int len, input int clr_at, input string tag);
    logic okw;
    okw = qualifies(b, len);
    for (int p = 0; p < len; p++) begin
      logic forced, e, h, c;
      @(negedge clk);
      if (have_prev) begin
        check(prev_tag, pwm_out, exp_out);
        check("R6 flag", viol_flag, exp_flag);
      end
      forced = (p >= W) && !okw;
      e = b[p] & ~forced;
      h = forced & b[p];
      c = (p == clr_at);
      frame_start = (p == 0);
      pwm_in = b[p];
      viol_clr = c;
      exp_out = e;
      exp_flag = h | (exp_flag & ~c);
      have_prev = 1'b1;
      prev_tag = tag;
    end
  endtask

  function automatic logic [FL-1:0] make_bits(input int kind, input int h);
    logic [FL-1:0] b = '0;
    for (int p = 0; p < FL; p++) begin
      case (kind)
        0: b[p] = (p < h);
        1: b[p] = (p >= FL - h);
        2: b[p] = (p >= (FL - h) / 2) && (p < (FL - h) / 2 + h);
        default: b[p] = ($urandom % 8) != 0;
      endcase
    end
    return b;
  endfunction

  initial begin
    logic [FL-1:0] b;
    void'($urandom(32'd1234));
    pwm_in = 1'b1; viol_clr = 1'b1; frame_start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out", pwm_out, 1'b0);
    check("R1 flag", viol_flag, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; pwm_in = 1'b0; viol_clr = 1'b0; frame_start = 1'b0;

    b = make_bits(1, FL - ML - 10);
    run_frame(b, FL, -1, "R2 low at start");
    b = make_bits(0, FL - 20);
    run_frame(b, FL, -1, "R2 96pct index");
    b = make_bits(0, FL - ML);
    run_frame(b, FL, -1, "R4 exact tail");
    b = make_bits(0, FL - 4);
    run_frame(b, FL, -1, "R3 20ns pulse");
    run_frame(b, FL, 100, "R6 clear");
    b = '1;
    run_frame(b, FL, W, "R7 set vs clear");
    run_frame(make_bits(1, FL - 40), FL, 5, "R6 clear again");
    b = '1;
    run_frame(b, FL - 5, -1, "R8 short frame");
    run_frame(b, W, 3, "R8 frame ends at window");

    for (int f = 0; f < 60; f++) begin
      int kind = $urandom % 4;
      int h = FL - ($urandom % 30);
      int len = (($urandom % 3) == 0) ? FL - ($urandom % 15) : FL;
      int clr = (($urandom % 3) == 0) ? $urandom % len : -1;
      b = make_bits(kind, h);
      run_frame(b, len, clr, "R3 random");
    end

    @(negedge clk);
    check(prev_tag, pwm_out, exp_out);
    check("R5 flag", viol_flag, exp_flag);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule